// File: doc/BRIEF.md
# Binary64 Compare to Condition Flags

This block compares two packed binary64 values, an operand D and an operand M. It reports the result as four processor condition flags, n, z, c and v, and also raises an invalid-operation flag, ioc. It works on the raw bit patterns and does not unpack or normalize them. The outputs are purely combinational, so a surrounding pipeline can register them in whatever stage suits it.

Two control inputs select the variant. `use_zero` replaces M with positive zero, which gives the compare-against-zero forms. `signal_qnan` makes a quiet NaN raise invalid in the same way that a signalling NaN always does, which gives the signalling compare. Storing the flags into a status register is left to the caller.

Top module: `fcmp_flag_gen`

## Requirements
- R1: An operand is a NaN when bits 62:52 are all ones and bits 51:0 are nonzero. If either operand is a NaN, the outputs are {n,z,c,v} = 0011.
- R2: The two operands are tested separately for invalid. A NaN operand raises ioc when its bit 51 is 0 (signalling), or when `signal_qnan` is 1. An infinity (all-ones exponent, zero fraction) never raises ioc.
- R3: If D and M are bit-identical, or both are zero of either sign, the outputs are {n,z,c,v} = 0110. This makes +0 equal to -0.
- R4: If neither operand is a NaN, they are not equal, and their signs (bit 63) differ, then a negative D gives 1000 (less) and a positive D gives 0010 (greater).
- R5: If both operands are non-NaN, positive and unequal, they are compared as unsigned integers. D below M gives 1000 and D above M gives 0010.
- R6: If both operands are non-NaN, negative and unequal, the integer order is inverted. The larger pattern of D gives 1000 and the smaller gives 0010.
- R7: With `use_zero` = 1, M is treated as +0 and its actual value, NaN included, has no effect on any output.
- R8: When no NaN is present, exactly one of less (1000), equal (0110) or greater (0010) is produced, with v = 0 and ioc = 0.
- R9: `signal_qnan` has no effect on the outputs when neither operand is a NaN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| d | input | 64 | Operand D, packed binary64 |
| m | input | 64 | Operand M, packed binary64 |
| use_zero | input | 1 | Compare D against +0 instead of M |
| signal_qnan | input | 1 | Quiet NaN also raises invalid |
| n | output | 1 | Less-than flag |
| z | output | 1 | Equal flag |
| c | output | 1 | Greater, equal or unordered flag |
| v | output | 1 | Unordered flag |
| ioc | output | 1 | Invalid-operation flag |

## Verification
The hardest outcomes to reach are on the boundary between the signed-zero rule and the inverted order for negative values. Examples are -0 against a negative denormal, and a NaN sitting on M while `use_zero` masks it. Uniform random patterns almost never produce these cases. A vector table therefore places them directly. A long pseudo-random sweep follows, with NaNs excluded and with M often forced to equal D or its negation. The expected order for that sweep comes from a real-number comparison of the decoded values.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

  // Operand facts gathered by the datapath and consumed by the control.
  typedef struct packed {
    logic dNan;
    logic mNan;
    logic dSig;
    logic mSig;
    logic identical;
    logic bothZero;
    logic signDiff;
    logic dNeg;
    logic magLess;
  } cmpStrobes_t;

  // Flag outputs produced by the control.
  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
    logic ioc;
  } cmpFlags_t;

endpackage

// File: rtl/fcmp_operand_class.sv
module fcmp_operand_class #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic [EXP_W+FRAC_W:0] opnd,
  output logic                  isNan,
  output logic                  isSig,
  output logic                  magZero,
  output logic                  sign
);
  localparam int TOT_W = 1 + EXP_W + FRAC_W;

  logic [EXP_W-1:0]  expField;
  logic [FRAC_W-1:0] fracField;

  always_comb begin
    expField  = opnd[TOT_W-2:FRAC_W];
    fracField = opnd[FRAC_W-1:0];
    isNan     = (&expField) && (|fracField);
    // The top fraction bit separates a quiet NaN from a signalling one.
    isSig     = isNan && !fracField[FRAC_W-1];
    magZero   = ~|opnd[TOT_W-2:0];
    sign      = opnd[TOT_W-1];
  end
endmodule

// File: rtl/fcmp_datapath.sv
module fcmp_datapath
  import fcmp_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic [EXP_W+FRAC_W:0] dIn,
  input  logic [EXP_W+FRAC_W:0] mIn,
  input  logic                  useZero,
  output cmpStrobes_t           strb
);
  localparam int TOT_W = 1 + EXP_W + FRAC_W;
  localparam int NUM_OP = 2;

  logic [TOT_W-1:0] mEff;
  logic [TOT_W-1:0] opVec   [NUM_OP];
  logic             nanV    [NUM_OP];
  logic             sigV    [NUM_OP];
  logic             zeroV   [NUM_OP];
  logic             signV   [NUM_OP];

  // Compare-with-zero forms swap in a positive zero for M.
  assign mEff     = useZero ? '0 : mIn;
  assign opVec[0] = dIn;
  assign opVec[1] = mEff;

  for (genvar gi = 0; gi < NUM_OP; gi++) begin : g_class
    fcmp_operand_class #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_class (
      .opnd    (opVec[gi]),
      .isNan   (nanV[gi]),
      .isSig   (sigV[gi]),
      .magZero (zeroV[gi]),
      .sign    (signV[gi])
    );
  end

  always_comb begin
    strb.dNan      = nanV[0];
    strb.mNan      = nanV[1];
    strb.dSig      = sigV[0];
    strb.mSig      = sigV[1];
    strb.identical = (dIn == mEff);
    strb.bothZero  = zeroV[0] && zeroV[1];
    strb.signDiff  = signV[0] ^ signV[1];
    strb.dNeg      = signV[0];
    // With equal signs the raw patterns order like the magnitudes.
    strb.magLess   = dIn[TOT_W-2:0] < mEff[TOT_W-2:0];
  end
endmodule

// File: rtl/fcmp_control.sv
module fcmp_control
  import fcmp_pkg::*;
(
  input  cmpStrobes_t strb,
  input  logic        signalQnan,
  output cmpFlags_t   flags
);
  typedef enum logic [1:0] {
    OUT_LESS,
    OUT_EQUAL,
    OUT_GREATER,
    OUT_UNORDERED
  } outcome_t;

  outcome_t outcome;
  logic     dInvalid;
  logic     mInvalid;

  always_comb begin
    if (strb.dNan || strb.mNan) begin
      outcome = OUT_UNORDERED;
    end else if (strb.identical || strb.bothZero) begin
      outcome = OUT_EQUAL;
    end else if (strb.signDiff) begin
      outcome = strb.dNeg ? OUT_LESS : OUT_GREATER;
    end else if (strb.dNeg) begin
      outcome = strb.magLess ? OUT_GREATER : OUT_LESS;
    end else begin
      outcome = strb.magLess ? OUT_LESS : OUT_GREATER;
    end
  end

  always_comb begin
    dInvalid  = strb.dNan && (strb.dSig || signalQnan);
    mInvalid  = strb.mNan && (strb.mSig || signalQnan);
    flags.ioc = dInvalid || mInvalid;
    flags.n   = (outcome == OUT_LESS);
    flags.z   = (outcome == OUT_EQUAL);
    flags.c   = (outcome != OUT_LESS);
    flags.v   = (outcome == OUT_UNORDERED);
  end
endmodule

// File: rtl/fcmp_flag_gen.sv
module fcmp_flag_gen
  import fcmp_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic [EXP_W+FRAC_W:0] d,
  input  logic [EXP_W+FRAC_W:0] m,
  input  logic                  use_zero,
  input  logic                  signal_qnan,
  output logic                  n,
  output logic                  z,
  output logic                  c,
  output logic                  v,
  output logic                  ioc
);
  cmpStrobes_t strb;
  cmpFlags_t   flags;

  fcmp_datapath #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_dp (
    .dIn     (d),
    .mIn     (m),
    .useZero (use_zero),
    .strb    (strb)
  );

  fcmp_control u_ctl (
    .strb       (strb),
    .signalQnan (signal_qnan),
    .flags      (flags)
  );

  assign n   = flags.n;
  assign z   = flags.z;
  assign c   = flags.c;
  assign v   = flags.v;
  assign ioc = flags.ioc;
endmodule

// File: rtl/fcmp_flag_gen_chk.sv
module fcmp_flag_gen_chk #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input logic [EXP_W+FRAC_W:0] d,
  input logic [EXP_W+FRAC_W:0] m,
  input logic                  use_zero,
  input logic                  signal_qnan,
  input logic                  n,
  input logic                  z,
  input logic                  c,
  input logic                  v,
  input logic                  ioc
);
  localparam int TOT_W = 1 + EXP_W + FRAC_W;

  logic [TOT_W-1:0] mSeen;
  logic dNanC, mNanC, anyNan, sigSeen;

  always_comb begin
    mSeen   = use_zero ? '0 : m;
    dNanC   = (&d[TOT_W-2:FRAC_W]) && (|d[FRAC_W-1:0]);
    mNanC   = (&mSeen[TOT_W-2:FRAC_W]) && (|mSeen[FRAC_W-1:0]);
    anyNan  = dNanC || mNanC;
    sigSeen = (dNanC && !d[FRAC_W-1]) || (mNanC && !mSeen[FRAC_W-1]);
  end

  always_comb begin
    if (anyNan) begin
      assert_nan_unordered_R1: assert (!n && !z && c && v);
    end
    if (ioc) begin
      assert_ioc_needs_nan_R2: assert (anyNan && (sigSeen || signal_qnan));
    end
    if (z) begin
      assert_equal_sets_c_R3: assert (c && !n && !v);
    end
    if (!anyNan && (d[TOT_W-1] != mSeen[TOT_W-1]) &&
        !((~|d[TOT_W-2:0]) && (~|mSeen[TOT_W-2:0]))) begin
      assert_sign_order_R4: assert (n == d[TOT_W-1] && c == !d[TOT_W-1]);
    end
    if (!anyNan) begin
      assert_one_outcome_R8: assert (!v && !ioc &&
        ($countones({n, z, (c && !z)}) == 1));
    end
  end
endmodule

bind fcmp_flag_gen fcmp_flag_gen_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .d           (d),
  .m           (m),
  .use_zero    (use_zero),
  .signal_qnan (signal_qnan),
  .n           (n),
  .z           (z),
  .c           (c),
  .v           (v),
  .ioc         (ioc)
);

// File: tb/fcmp_flag_gen_tb.sv
module fcmp_flag_gen_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] d = '0;
  logic [63:0] m = '0;
  logic        use_zero = 1'b0;
  logic        signal_qnan = 1'b0;
  logic        n, z, c, v, ioc;
  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  fcmp_flag_gen u_dut (
    .d(d), .m(m), .use_zero(use_zero), .signal_qnan(signal_qnan),
    .n(n), .z(z), .c(c), .v(v), .ioc(ioc)
  );

  localparam logic [63:0] P1   = 64'h3FF0000000000000;
  localparam logic [63:0] P2   = 64'h4000000000000000;
  localparam logic [63:0] N1   = 64'hBFF0000000000000;
  localparam logic [63:0] N2   = 64'hC000000000000000;
  localparam logic [63:0] PZ   = 64'h0000000000000000;
  localparam logic [63:0] NZ   = 64'h8000000000000000;
  localparam logic [63:0] PINF = 64'h7FF0000000000000;
  localparam logic [63:0] NINF = 64'hFFF0000000000000;
  localparam logic [63:0] QNAN = 64'h7FF8000000000000;
  localparam logic [63:0] NQN  = 64'hFFF8000000000001;
  localparam logic [63:0] SNAN = 64'h7FF0000000000001;
  localparam logic [63:0] PDEN = 64'h0000000000000001;
  localparam logic [63:0] NDEN = 64'h8000000000000001;

  localparam logic [3:0] LT = 4'b1000;
  localparam logic [3:0] EQ = 4'b0110;
  localparam logic [3:0] GT = 4'b0010;
  localparam logic [3:0] UN = 4'b0011;

  // Entry: {tag, d, m, use_zero, signal_qnan, nzcv, ioc}
  localparam int NV = 24;
  localparam logic [138:0] VEC [NV] = '{
    {4'd5, P1,   P2,   1'b0, 1'b0, LT, 1'b0},   // R5 less
    {4'd5, P2,   P1,   1'b0, 1'b0, GT, 1'b0},   // R5 greater
    {4'd6, N1,   N2,   1'b0, 1'b0, GT, 1'b0},   // R6 inverted
    {4'd6, N2,   N1,   1'b0, 1'b0, LT, 1'b0},   // R6 inverted
    {4'd4, N1,   P1,   1'b0, 1'b0, LT, 1'b0},   // R4 negative D
    {4'd4, P1,   N2,   1'b0, 1'b0, GT, 1'b0},   // R4 positive D
    {4'd3, PZ,   NZ,   1'b0, 1'b0, EQ, 1'b0},   // R3 +0 vs -0
    {4'd3, NZ,   PZ,   1'b0, 1'b0, EQ, 1'b0},   // R3 -0 vs +0
    {4'd3, N2,   N2,   1'b0, 1'b0, EQ, 1'b0},   // R3 identical
    {4'd1, QNAN, P1,   1'b0, 1'b0, UN, 1'b0},   // R1 quiet NaN on D
    {4'd1, P1,   NQN,  1'b0, 1'b0, UN, 1'b0},   // R1 negative NaN on M
    {4'd2, QNAN, P1,   1'b0, 1'b1, UN, 1'b1},   // R2 quiet, signalling mode
    {4'd2, P1,   SNAN, 1'b0, 1'b0, UN, 1'b1},   // R2 signalling NaN
    {4'd2, PINF, P1,   1'b0, 1'b1, GT, 1'b0},   // R2 infinity is not NaN
    {4'd3, PINF, PINF, 1'b0, 1'b0, EQ, 1'b0},   // R3 infinities
    {4'd6, NINF, N1,   1'b0, 1'b0, LT, 1'b0},   // R6 -inf below -1
    {4'd7, P2,   N1,   1'b1, 1'b0, GT, 1'b0},   // R7 compare with zero
    {4'd7, N1,   QNAN, 1'b1, 1'b1, LT, 1'b0},   // R7 NaN on M masked
    {4'd7, NZ,   P2,   1'b1, 1'b0, EQ, 1'b0},   // R7 -0 vs zero
    {4'd5, PDEN, PZ,   1'b0, 1'b0, GT, 1'b0},   // R5 denormal above zero
    {4'd6, NDEN, NZ,   1'b0, 1'b0, LT, 1'b0},   // R6 negative denormal
    {4'd9, P1,   P2,   1'b0, 1'b1, LT, 1'b0},   // R9 mode ignored
    {4'd9, NZ,   PZ,   1'b0, 1'b1, EQ, 1'b0},   // R9 mode ignored
    {4'd2, SNAN, QNAN, 1'b0, 1'b0, UN, 1'b1}    // R2 either operand
  };

  task automatic check(input int tag, input string what,
                       input logic [4:0] got, input logic [4:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL R%0d %s: got nzcv_ioc=%b expected %b", tag, what, got, exp);
    end
  endtask

  task automatic apply(input logic [63:0] dv, input logic [63:0] mv,
                       input logic uz, input logic sq);
    @(negedge clk);
    d = dv; m = mv; use_zero = uz; signal_qnan = sq;
    #2;
  endtask

  logic [63:0] lfsr = 64'h9E3779B97F4A7C15;
  function automatic logic [63:0] step(input logic [63:0] s);
    logic [63:0] x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 7);
    x = x ^ (x << 17);
    return x;
  endfunction

  function automatic bit isNanBits(input logic [63:0] x);
    return (&x[62:52]) && (|x[51:0]);
  endfunction

  initial begin
    repeat (2) @(posedge clk);
    rst = 1'b0;
    // Idle inputs: +0 against +0 reads as equal (R3)
    #2;
    check(3, "idle state", {n, z, c, v, ioc}, {EQ, 1'b0});

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][134:71], VEC[i][70:7], VEC[i][6], VEC[i][5]);
      check(int'(VEC[i][138:135]), $sformatf("vector %0d", i),
            {n, z, c, v, ioc}, VEC[i][4:0]);
    end

    // R7: M swept while use_zero is set, result must track D vs +0 only
    for (int i = 0; i < 8; i++) begin
      lfsr = step(lfsr);
      apply(P1, lfsr, 1'b1, 1'b1);
      check(7, "M ignored under use_zero", {n, z, c, v, ioc}, {GT, 1'b0});
    end

    // R8 / R5 / R6 / R4: random ordered sweep against a real-number reference
    for (int i = 0; i < 3000; i++) begin
      logic [63:0] dv, mv;
      logic [3:0]  ex;
      real         dr, mr;
      lfsr = step(lfsr); dv = lfsr;
      lfsr = step(lfsr); mv = lfsr;
      if (lfsr[1:0] == 2'd0) mv = dv;
      if (lfsr[3:2] == 2'd1) mv = dv ^ 64'h8000000000000000;
      if (lfsr[5:4] == 2'd2) mv[62:52] = dv[62:52];
      if (isNanBits(dv)) dv[62] = 1'b0;
      if (isNanBits(mv)) mv[62] = 1'b0;
      dr = $bitstoreal(dv);
      mr = $bitstoreal(mv);
      ex = (dr < mr) ? LT : ((dr > mr) ? GT : EQ);
      apply(dv, mv, 1'b0, lfsr[9]);
      check(8, "random ordered", {n, z, c, v, ioc}, {ex, 1'b0});
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule